// File: doc/BRIEF.md
# Programmable Line-Inversion Signal Generator

This block produces the polarity-reversal signal that an LCD row driver uses to alternate drive polarity and keep crosstalk low. It counts the falling edges of the line clock and flips the polarity signal each time a programmed number of lines has passed. A static 5-bit strap code selects that number, from 2 to 31 lines.

A strap code of zero stops internal generation. The shared polarity pin then becomes an input, and the value arriving from outside sets the drive polarity. The block drives the pin through an output value and an output enable, and it gives the internal drive logic a separate polarity output. Code 1 is not a legal setting. The block treats it as a 2-line period and raises an error flag.

The line clock is an ordinary input that is sampled on the system clock. A falling edge is seen as a high sample followed by a low sample. A new strap code does not take effect in the middle of a period. It is loaded when the current period wraps, so no short period is ever produced.

Top module: `line_inv_gen`

## Requirements
- R1: While rst_ni is low, the counter is held at 0 and the polarity is held at 0. This applies at once, with no clock edge needed. pin_m_o and drive_m_o read 0 in an internal mode.
- R2: With code N in 2..31, held since reset, drive_m_o equals (k / N) mod 2 after k line-clock falling edges, where the division is an integer division.
- R3: Only a falling edge of line_clk_i advances the count. A rising edge, or holding the line clock high for any number of cycles, leaves the polarity unchanged.
- R4: Code 1 behaves like code 2, and sel_err_o is 1 while the code is 1. sel_err_o is 0 for every other code.
- R5: With code 0, pin_m_oe_o is 0 and drive_m_o follows pin_m_i combinationally. Line-clock edges change neither the held polarity on pin_m_o nor the count.
- R6: With a nonzero code, pin_m_oe_o is 1 and pin_m_o equals drive_m_o.
- R7: If the code changes between two nonzero values in mid-period, the current period completes with the old length. The new length applies from that wrap onward.
- R8: Leaving code 0 for a nonzero code starts a fresh count from 0, beginning with the polarity value held before code 0 was selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_clk_i | input | 1 | Line clock, synchronous to clk_i; its falling edge counts one line |
| period_sel_i | input | 5 | Strap code: 0 selects external polarity, 2..31 sets lines per half period, 1 is illegal |
| pin_m_i | input | 1 | Polarity value read from the shared pin |
| pin_m_o | output | 1 | Polarity value driven onto the shared pin |
| pin_m_oe_o | output | 1 | Output enable for the shared pin |
| drive_m_o | output | 1 | Polarity used by the internal drive logic |
| sel_err_o | output | 1 | High while the strap code is the illegal value 1 |

## Verification
The assertions take line_clk_i to be synchronous to clk_i, so each falling edge appears as exactly one high sample followed by a low sample. They also take the strap code to change only on clock edges. The bench drives every input at the falling edge of clk_i and holds the line clock high and low for at least one full cycle each. The sweep covers every legal period, with each code applied under reset before any line is counted. Code changes happen only between line pulses, so the wrap-time loading of the period is observed at well-defined line counts.

// File: rtl/line_inv_pkg.sv
package line_inv_pkg;
  localparam int unsigned SEL_W = 5;

  typedef enum logic [1:0] {
    MODE_EXT  = 2'd0,
    MODE_FIX2 = 2'd1,
    MODE_PROG = 2'd2
  } inv_mode_e;
endpackage

// File: rtl/line_edge_det.sv
module line_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_clk_i,
  output logic fall_o
);
  logic line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 1'b0;
    else         line_q <= line_clk_i;
  end

  assign fall_o = line_q & ~line_clk_i;

  assert_fall_after_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/line_period_decode.sv
module line_period_decode
  import line_inv_pkg::*;
#(
  parameter int unsigned W = SEL_W
) (
  input  logic [W-1:0] sel_i,
  output logic [W-1:0] eff_o,
  output logic         ext_o,
  output logic         err_o
);
  inv_mode_e mode;

  always_comb begin
    if (sel_i == '0) begin
      mode  = MODE_EXT;
      eff_o = '0;
    end else if (sel_i == W'(1)) begin
      mode  = MODE_FIX2;
      eff_o = W'(2);  // illegal code: fall back to shortest legal period
    end else begin
      mode  = MODE_PROG;
      eff_o = sel_i;
    end
  end

  assign ext_o = (mode == MODE_EXT);
  assign err_o = (mode == MODE_FIX2);
endmodule

// File: rtl/line_counter.sv
module line_counter #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fall_i,
  input  logic         ext_i,
  input  logic [W-1:0] eff_i,
  output logic         m_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d, per_q, per_d, act;
  logic         m_q, m_d, wrap;

  // per_q == 0 means no period latched yet: take the strap value directly
  assign act  = (per_q == '0) ? eff_i : per_q;
  assign wrap = fall_i && !ext_i && (cnt_q == act - ONE);

  always_comb begin
    cnt_d = cnt_q;
    per_d = per_q;
    m_d   = m_q;
    if (ext_i) begin
      cnt_d = '0;
      per_d = '0;
    end else begin
      per_d = act;
      if (wrap) begin
        cnt_d = '0;
        m_d   = ~m_q;
        per_d = eff_i;
      end else if (fall_i) begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
      m_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
      m_q   <= m_d;
    end
  end

  assign m_o = m_q;

  assert_cnt_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_q != '0) |-> (cnt_q < per_q));
  assert_no_edge_no_flip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(m_q));
  assert_no_unit_period_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_q != ONE);
  assert_ext_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_i |=> (cnt_q == '0) && $stable(m_q));
  assert_period_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_q != '0 && !ext_i && !wrap) |=> $stable(per_q));
endmodule

// File: rtl/line_inv_gen.sv
module line_inv_gen
  import line_inv_pkg::*;
#(
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_clk_i,
  input  logic [SW-1:0] period_sel_i,
  input  logic          pin_m_i,
  output logic          pin_m_o,
  output logic          pin_m_oe_o,
  output logic          drive_m_o,
  output logic          sel_err_o
);
  logic          fall, ext, m_int;
  logic [SW-1:0] eff;

  line_edge_det u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_clk_i (line_clk_i),
    .fall_o     (fall)
  );

  line_period_decode #(.W(SW)) u_dec (
    .sel_i (period_sel_i),
    .eff_o (eff),
    .ext_o (ext),
    .err_o (sel_err_o)
  );

  line_counter #(.W(SW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fall_i (fall),
    .ext_i  (ext),
    .eff_i  (eff),
    .m_o    (m_int)
  );

  assign pin_m_o    = m_int;
  assign pin_m_oe_o = !ext;
  assign drive_m_o  = ext ? pin_m_i : m_int;

  assert_err_drives_pin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_err_o |-> pin_m_oe_o && (drive_m_o == pin_m_o));
endmodule

// File: tb/line_inv_gen_bench.sv
`timescale 1ns/1ps
module line_inv_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_clk = 1'b0;
  logic [4:0] sel = 5'd2;
  logic       pin_in = 1'b0;
  logic       pin_out, pin_oe, drv, err;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  line_inv_gen u_line_inv_gen (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .line_clk_i   (line_clk),
    .period_sel_i (sel),
    .pin_m_i      (pin_in),
    .pin_m_o      (pin_out),
    .pin_m_oe_o   (pin_oe),
    .drive_m_o    (drv),
    .sel_err_o    (err)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [4:0] code);
    @(negedge clk);
    rst_n = 1'b0; line_clk = 1'b0; sel = code;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_line;
    @(negedge clk); line_clk = 1'b1;
    @(negedge clk); line_clk = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    do_reset(5'd5);
    chk("R1 drive", drv, 1'b0);
    chk("R1 pin", pin_out, 1'b0);

    // R2/R6/R4: sweep all legal periods
    for (int n = 2; n <= 31; n++) begin
      do_reset(5'(n));
      chk("R6 oe", pin_oe, 1'b1);
      chk("R4 err low", err, 1'b0);
      for (int k = 1; k <= 2 * n + 1; k++) begin
        pulse_line();
        chk("R2 period", drv, 1'((k / n) % 2));
        chk("R6 pin", pin_out, drv);
      end
    end

    // R4: illegal code 1 acts as period 2
    do_reset(5'd1);
    chk("R4 err high", err, 1'b1);
    chk("R4 oe", pin_oe, 1'b1);
    for (int k = 1; k <= 6; k++) begin
      pulse_line();
      chk("R4 fallback", drv, 1'((k / 2) % 2));
    end

    // R3: long high level and rising edge do nothing
    do_reset(5'd3);
    pulse_line(); pulse_line();
    @(negedge clk); line_clk = 1'b1;
    repeat (10) @(negedge clk);
    chk("R3 high hold", drv, 1'b0);
    line_clk = 1'b0;
    @(negedge clk);
    chk("R3 fall counts", drv, 1'b1);

    // R7: mid-period code change waits for wrap
    do_reset(5'd4);
    pulse_line(); pulse_line();
    sel = 5'd6;
    for (int k = 3; k <= 16; k++) begin
      pulse_line();
      chk("R7 deferred change", drv, (k < 4) ? 1'b0 : (k < 10) ? 1'b1 : (k < 16) ? 1'b0 : 1'b1);
    end

    // R5/R8: external mode
    do_reset(5'd4);
    for (int k = 0; k < 5; k++) pulse_line();
    chk("R8 before ext", drv, 1'b1);
    sel = 5'd0; pin_in = 1'b0;
    #1;
    chk("R5 oe low", pin_oe, 1'b0);
    chk("R5 follow 0", drv, 1'b0);
    pin_in = 1'b1; #1;
    chk("R5 follow 1", drv, 1'b1);
    pin_in = 1'b0;
    for (int k = 0; k < 7; k++) pulse_line();
    chk("R5 pin held", pin_out, 1'b1);
    chk("R5 follow after edges", drv, 1'b0);
    chk("R4 err in ext", err, 1'b0);
    sel = 5'd3;
    pulse_line(); chk("R8 restart 1", drv, 1'b1);
    pulse_line(); chk("R8 restart 2", drv, 1'b1);
    pulse_line(); chk("R8 restart 3", drv, 1'b0);

    // R1: asynchronous reset mid-run
    do_reset(5'd2);
    pulse_line(); pulse_line();
    chk("R1 pre", drv, 1'b1);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async", drv, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule